// File: doc/BRIEF.md
# Accumulator CPU Execution Core

This block is the execution engine of a small 8-bit programmable controller. It reads one 16-bit instruction per clock from a ten-entry program store. The store sits outside the block, and the block addresses it through its program counter output. Each instruction updates an accumulator, a helper register, a zero flag, a visible output register or the program counter. Arithmetic and logic combine the accumulator with the helper register. Two output instructions copy either register to the output port. Conditional branches test the zero flag.

The surrounding system first fills the store while the run input is low. It then raises run, and the core starts executing at address 0. Execution stops on a halt instruction. Lowering run returns the core to address 0 and clears the halt, so that raising run again restarts the program. The accumulator, helper register, flag and output keep their values across such a restart.

Top module: `acc_core`

## Requirements
- R1: While reset is high at a clock edge, the core clears the accumulator, the helper register, the zero flag, the output port, the program counter and the halted flag. After reset the output port reads 0x00, pc reads 0 and halted reads 0.
- R2: The opcode is instr[15:12] and the immediate is instr[7:0]. Opcode 0x1 loads the immediate into the accumulator and updates Z. Opcode 0x2 loads the immediate into the helper register and leaves the accumulator unchanged. Opcode 0x9 copies the accumulator to the output port and opcode 0xF copies the helper register there. No other opcode changes the output port. Opcode 0x0 does nothing.
- R3: Opcode 0x3 writes accumulator + helper to the accumulator and opcode 0x4 writes accumulator − helper there, both modulo 256. Both update Z.
- R4: Opcodes 0x5, 0x6 and 0x7 write the bitwise AND, OR and XOR of the accumulator and the helper register to the accumulator. All three update Z.
- R5: Opcode 0x8 sets Z to 1 exactly when the accumulator equals the helper register and leaves the accumulator unchanged.
- R6: Opcode 0xE copies the helper register into the accumulator and sets Z from the copied value.
- R7: Opcode 0xA always jumps to the target in instr[3:0]. Opcode 0xB jumps only when Z is 1 and opcode 0xC only when Z is 0. An untaken branch moves on to the next address.
- R8: A jump target of 10 or above sends execution to address 0.
- R9: Sequential execution past address 9 continues at address 0, so pc never leaves the range 0 to 9.
- R10: Opcode 0xD sets halted. While halted and run stays high, pc, the output port and all registers hold.
- R11: While run is low, pc returns to 0 and halted clears, while the data registers and the output port hold. Execution begins at address 0 on the first edge at which run is high.
- R12: Each instruction completes in one clock, so pc advances once per edge while run is high and the core is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to execute, low to hold at address 0 |
| instr | input | 16 | Instruction word read from the store at `pc` |
| pc | output | 4 | Program counter, used as the store read address |
| port_out | output | 8 | Visible output register |
| halted | output | 1 | High after a halt instruction |

## Verification
The bench builds the core with its defaults: 8-bit data, 16-bit instructions and ten program slots. With ten slots the 4-bit target field can encode addresses 10 to 15, so the invalid-target redirect can be reached. The sequential wrap from address 9 is also reached by a program that runs off the end of the store. Five short programs are placed in a bench-side store model. They cover the ALU operations, taken and untaken branches on both flag states, the halt freeze, and a restart by lowering run. The accumulator state is made visible at the port through output instructions.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 4;
    localparam int TGT_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'h0,
        OP_LDA  = 4'h1,
        OP_LDR  = 4'h2,
        OP_ADD  = 4'h3,
        OP_SUB  = 4'h4,
        OP_AND  = 4'h5,
        OP_OR   = 4'h6,
        OP_XOR  = 4'h7,
        OP_CMP  = 4'h8,
        OP_OUTA = 4'h9,
        OP_JMP  = 4'hA,
        OP_BZ   = 4'hB,
        OP_BNZ  = 4'hC,
        OP_HALT = 4'hD,
        OP_MOVA = 4'hE,
        OP_OUTR = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_JUMP = 2'd1,
        FLOW_STOP = 2'd2
    } flow_e;

    typedef struct packed {
        logic  acc_we;
        logic  r1_we;
        logic  z_we;
        logic  out_we;
        logic  out_from_r1;
        flow_e flow;
    } ctrl_t;

    function automatic ctrl_t decode(opcode_e op, logic z);
        ctrl_t c;
        c      = '0;
        c.flow = FLOW_SEQ;
        case (op)
            OP_LDA, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MOVA: begin
                c.acc_we = 1'b1;
                c.z_we   = 1'b1;
            end
            OP_LDR:  c.r1_we = 1'b1;
            OP_CMP:  c.z_we  = 1'b1;
            OP_OUTA: c.out_we = 1'b1;
            OP_OUTR: begin
                c.out_we      = 1'b1;
                c.out_from_r1 = 1'b1;
            end
            OP_JMP:  c.flow = FLOW_JUMP;
            OP_BZ:   c.flow = z ? FLOW_JUMP : FLOW_SEQ;
            OP_BNZ:  c.flow = z ? FLOW_SEQ : FLOW_JUMP;
            OP_HALT: c.flow = FLOW_STOP;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] r1,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] res,
    output logic              zero
);

    always_comb begin
        case (op)
            OP_LDA:          res = imm;
            OP_ADD:          res = acc + r1;
            OP_SUB, OP_CMP:  res = acc - r1;
            OP_AND:          res = acc & r1;
            OP_OR:           res = acc | r1;
            OP_XOR:          res = acc ^ r1;
            OP_MOVA:         res = r1;
            default:         res = acc;
        endcase
        zero = (res == '0);
    end

endmodule

// File: rtl/acc_core_pcgen.sv
module acc_core_pcgen
    import acc_core_pkg::*;
#(
    parameter int SLOTS = 10,
    localparam int PC_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TGT_W-1:0] tgt,
    input  flow_e            flow,
    output logic [PC_W-1:0]  pc_next
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;

    always_comb begin
        seq_pc  = (pc == PC_W'(SLOTS - 1)) ? '0 : pc + PC_W'(1);
        jump_pc = (int'(tgt) < SLOTS) ? PC_W'(tgt) : '0;
        case (flow)
            FLOW_JUMP: pc_next = jump_pc;
            FLOW_STOP: pc_next = pc;
            default:   pc_next = seq_pc;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 16,
    parameter int SLOTS   = 10,
    localparam int PC_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [INSTR_W-1:0] instr,
    output logic [PC_W-1:0]    pc,
    output logic [DATA_W-1:0]  port_out,
    output logic               halted
);

    logic [DATA_W-1:0] acc_q, r1_q, out_q;
    logic [PC_W-1:0]   pc_q, pc_next;
    logic              z_q, halted_q;

    opcode_e           op;
    logic [DATA_W-1:0] imm;
    logic [TGT_W-1:0]  tgt;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              exec;
    logic              unused_bits;

    assign op          = opcode_e'(instr[INSTR_W-1 -: OPC_W]);
    assign imm         = instr[DATA_W-1:0];
    assign tgt         = instr[TGT_W-1:0];
    assign unused_bits = ^instr[INSTR_W-OPC_W-1:DATA_W];
    assign ctrl        = decode(op, z_q);
    assign exec        = run && !halted_q;

    acc_core_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (op),
        .acc  (acc_q),
        .r1   (r1_q),
        .imm  (imm),
        .res  (alu_res),
        .zero (alu_zero)
    );

    acc_core_pcgen #(.SLOTS(SLOTS)) u_pcgen (
        .pc      (pc_q),
        .tgt     (tgt),
        .flow    (ctrl.flow),
        .pc_next (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            r1_q     <= '0;
            out_q    <= '0;
            pc_q     <= '0;
            z_q      <= 1'b0;
            halted_q <= 1'b0;
        end else if (!run) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            pc_q <= pc_next;
            if (ctrl.acc_we) acc_q <= alu_res;
            if (ctrl.r1_we)  r1_q  <= imm;
            if (ctrl.z_we)   z_q   <= alu_zero;
            if (ctrl.out_we) out_q <= ctrl.out_from_r1 ? r1_q : acc_q;
            if (ctrl.flow == FLOW_STOP) halted_q <= 1'b1;
        end
    end

    assign pc       = pc_q;
    assign port_out = out_q;
    assign halted   = halted_q;

    AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(pc_q) < SLOTS); // R9

    AST_RUN_LOW_HOME: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pc_q == '0 && !halted_q)); // R11

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (run && halted_q) |=> (halted_q && $stable(pc_q) && $stable(out_q) && $stable(acc_q))); // R10

    AST_HALT_FROM_OPCODE: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_q) |-> $past(op) == OP_HALT); // R10

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (exec && op == OP_CMP) |=> $stable(acc_q)); // R5

    AST_OUT_ONLY_ON_OUTPUT_OP: assert property (@(posedge clk) disable iff (rst)
        !(exec && (op == OP_OUTA || op == OP_OUTR)) |=> $stable(out_q)); // R2

    AST_LDR_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (exec && op == OP_LDR) |=> $stable(acc_q)); // R2

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      tag;
        logic [7:0] out;
        logic       halt;
        logic [3:0] pc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] instr;
    logic [3:0]  pc;
    logic [7:0]  port_out;
    logic        halted;

    logic [15:0] prog [0:15];
    exp_t        sb_q [$];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign instr = prog[pc];

    acc_core dut (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .instr    (instr),
        .pc       (pc),
        .port_out (port_out),
        .halted   (halted)
    );

    // monitor: pops expected items and compares them to the ports
    initial begin
        forever begin
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (port_out !== e.out || halted !== e.halt || pc !== e.pc) begin
                    n_fail++;
                    $display("FAIL %s: got out=%02h halted=%0b pc=%0d, expected out=%02h halted=%0b pc=%0d",
                             e.tag, port_out, halted, pc, e.out, e.halt, e.pc);
                end
            end
        end
    end

    task automatic expect_state(input string tag, input logic [7:0] o,
                                input logic h, input logic [3:0] p);
        exp_t e;
        e.tag = tag; e.out = o; e.halt = h; e.pc = p;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = 16'hD000;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        #3;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got run still active, expected completion");
            finish_run();
        end
    end

    initial begin
        clear_prog();
        do_reset();
        expect_state("R1 reset state", 8'h00, 1'b0, 4'd0);

        // program 1: load helper, copy, both outputs, halt
        prog[0] = 16'h2033; prog[1] = 16'hE000; prog[2] = 16'h9000;
        prog[3] = 16'hF000; prog[4] = 16'hD000;
        run = 1'b1;
        step(3);
        expect_state("R6 copy helper then R2 output acc", 8'h33, 1'b0, 4'd3);
        step(2);
        expect_state("R10 halt sets flag", 8'h33, 1'b1, 4'd4);
        step(3);
        expect_state("R10 halted core holds", 8'h33, 1'b1, 4'd4);
        run = 1'b0;
        step(1);
        expect_state("R11 run low homes and clears halt", 8'h33, 1'b0, 4'd0);
        run = 1'b1;
        step(3);
        expect_state("R11 restart from address 0", 8'h33, 1'b0, 4'd3);

        // program 2: add, sub, xor
        clear_prog();
        do_reset();
        prog[0] = 16'h1005; prog[1] = 16'h2003; prog[2] = 16'h3000;
        prog[3] = 16'h9000; prog[4] = 16'h4000; prog[5] = 16'h9000;
        prog[6] = 16'h7000; prog[7] = 16'h9000; prog[8] = 16'hD000;
        run = 1'b1;
        step(4);
        expect_state("R3 add 5+3 and R12 one per clock", 8'h08, 1'b0, 4'd4);
        step(2);
        expect_state("R3 sub 8-3", 8'h05, 1'b0, 4'd6);
        step(2);
        expect_state("R4 xor 5^3", 8'h06, 1'b0, 4'd8);
        step(1);
        expect_state("R10 halt at 8", 8'h06, 1'b1, 4'd8);

        // program 3: and, or, cmp, taken BZ, wrap
        clear_prog();
        do_reset();
        prog[0] = 16'h10F0; prog[1] = 16'h203C; prog[2] = 16'h5000;
        prog[3] = 16'h9000; prog[4] = 16'h6000; prog[5] = 16'h8000;
        prog[6] = 16'hB009; prog[7] = 16'h1000; prog[8] = 16'hD000;
        prog[9] = 16'h9000;
        run = 1'b1;
        step(4);
        expect_state("R4 and F0&3C", 8'h30, 1'b0, 4'd4);
        step(3);
        expect_state("R7 BZ taken after R5 equal compare", 8'h30, 1'b0, 4'd9);
        step(1);
        expect_state("R5 cmp keeps acc, R4 or, R9 wrap to 0", 8'h3C, 1'b0, 4'd0);
        run = 1'b0;
        step(2);
        expect_state("R11 run low holds output and pc 0", 8'h3C, 1'b0, 4'd0);

        // program 4: untaken branches, invalid jump
        clear_prog();
        do_reset();
        prog[0] = 16'h1007; prog[1] = 16'h2007; prog[2] = 16'h7000;
        prog[3] = 16'hC009; prog[4] = 16'hF000; prog[5] = 16'h1001;
        prog[6] = 16'hB009; prog[7] = 16'h9000; prog[8] = 16'hA00F;
        run = 1'b1;
        step(4);
        expect_state("R7 BNZ untaken after R4 xor zero", 8'h00, 1'b0, 4'd4);
        step(1);
        expect_state("R2 helper to output", 8'h07, 1'b0, 4'd5);
        step(2);
        expect_state("R7 BZ untaken after R2 nonzero load", 8'h07, 1'b0, 4'd7);
        step(1);
        expect_state("R2 load imm to acc then output", 8'h01, 1'b0, 4'd8);
        step(1);
        expect_state("R8 jump to 15 goes to 0", 8'h01, 1'b0, 4'd0);

        // program 5: valid jump, copy zero, BZ to 0
        clear_prog();
        do_reset();
        prog[0] = 16'h2055; prog[1] = 16'hA004; prog[2] = 16'hD000;
        prog[3] = 16'hD000; prog[4] = 16'hE000; prog[5] = 16'h9000;
        prog[6] = 16'h2000; prog[7] = 16'hE000; prog[8] = 16'hB000;
        run = 1'b1;
        step(2);
        expect_state("R7 jump to 4", 8'h00, 1'b0, 4'd4);
        step(2);
        expect_state("R6 copy helper to acc", 8'h55, 1'b0, 4'd6);
        step(3);
        expect_state("R6 copy of zero sets Z, BZ to 0", 8'h55, 1'b0, 4'd0);
        step(1);
        expect_state("R12 next instruction next clock", 8'h55, 1'b0, 4'd1);

        done = 1'b1;
        finish_run();
    end

endmodule